// File: doc/BRIEF.md
# Rank Activity and Idle Tracker

This block follows the work still owed to one DRAM rank and reports whether that rank may drop into a low-power state. It keeps three saturating 8-bit counts. The first counts queued reads. The second counts queued writes that were not merged into an earlier entry. The third counts outstanding events: issued reads awaiting their response, pending precharge timers, a running refresh, and the single write-completion timer.

The scheduler sends one-cycle pulses as requests are queued, issued and completed. It also supplies the bus direction it will serve next, a flag that is high while a refresh is in progress, the current time, and the ready time of each issued write. The block returns two flags. One says the rank may enter power-down. The other says a rank held in self-refresh must be woken because work is waiting for it. A decrement of an empty count sets a sticky error flag.

Top module: `rank_idle_tracker`

## Requirements
- R1: A synchronous reset clears the three counts, the write-completion timer and the error flag. After reset, `lp_ready` is 1 and `sref_exit` is 0 for either direction.
- R2: The read count rises by one on `rd_enq` and falls by one on `rd_resp_done`.
- R3: The write count rises by one on `wr_enq_new` and falls by one on `wr_issue`.
- R4: The event count rises by one for each of `rd_issue`, `pre_start` and `ref_start`, and falls by one for each of `rd_resp_done`, `pre_done` and `ref_done`.
- R5: A `wr_issue` with the write timer idle starts the timer at `wr_ready_time` and adds one event. A `wr_issue` with the timer running only moves the deadline, and only to a later time. The timer ends in the first cycle in which `now >= deadline`, and it then removes one event.
- R6: Work is queued when `next_dir_wr`=0 and the read count is nonzero, or when `next_dir_wr`=1 and the write count is nonzero. While `ref_running`=0, `lp_ready` is 1 only if nothing is queued and the event count is zero.
- R7: While `ref_running`=1, `lp_ready` ignores the event count and is 1 exactly when nothing is queued.
- R8: `sref_exit` is 1 when the read count is nonzero, or when `next_dir_wr`=1 and the write count is nonzero.
- R9: A decrement that would take a count below zero sets `underflow_err`, which stays set until reset. That count is left at zero.
- R10: Increments and decrements that reach one count in the same cycle are netted against each other. An increment cancels a decrement without raising an error.
- R11: A count saturates at 255 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_enq | input | 1 | A read burst was queued for the rank |
| rd_resp_done | input | 1 | A read response left the response queue |
| wr_enq_new | input | 1 | A non-merged write burst was queued |
| wr_issue | input | 1 | A write was issued to the bus |
| rd_issue | input | 1 | A read was issued to the bus |
| pre_start | input | 1 | A precharge timer was newly started |
| pre_done | input | 1 | A precharge timer completed |
| ref_start | input | 1 | A refresh began |
| ref_done | input | 1 | A refresh completed |
| wr_ready_time | input | TIME_W | Ready time of the write issued this cycle |
| now | input | TIME_W | Current time |
| next_dir_wr | input | 1 | Next bus direction: 1 for write, 0 for read |
| ref_running | input | 1 | A refresh is in progress |
| lp_ready | output | 1 | The rank may enter a low-power state |
| sref_exit | output | 1 | Wake the rank from self-refresh |
| underflow_err | output | 1 | Sticky flag: a count was decremented below zero |

## Verification
The flags are tested against a sequence of pulse mixes. Each mix changes one count or one input in a way that flips exactly one flag.

- Switching `next_dir_wr` while reads and writes are both queued separates the direction rule of `lp_ready` from the stricter read rule of `sref_exit`.
- Raising `ref_running` while a precharge is pending shows whether the event count is bypassed during refresh.
- Same-cycle increment and decrement mixes show whether the updates are netted.
- An extra decrement on an empty count, followed by one increment, shows whether the count was clamped at zero or wrapped.

The write timer is given a later deadline, then an earlier one, and is sampled on both sides of the deadline that survives. This shows that extensions are not counted as new events and that a deadline never moves earlier.

// File: rtl/rank_idle_tracker.sv
module rank_idle_tracker #(
  parameter int CNT_W  = 8,
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_enq,
  input  logic              rd_resp_done,
  input  logic              wr_enq_new,
  input  logic              wr_issue,
  input  logic              rd_issue,
  input  logic              pre_start,
  input  logic              pre_done,
  input  logic              ref_start,
  input  logic              ref_done,
  input  logic [TIME_W-1:0] wr_ready_time,
  input  logic [TIME_W-1:0] now,
  input  logic              next_dir_wr,
  input  logic              ref_running,
  output logic              lp_ready,
  output logic              sref_exit,
  output logic              underflow_err
);
  localparam int SUM_W = CNT_W + 2;
  localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'({CNT_W{1'b1}});

  logic [CNT_W-1:0]  rd_cnt, wr_cnt, ev_cnt;
  logic [CNT_W-1:0]  rd_nxt, wr_nxt, ev_nxt;
  logic              rd_uf, wr_uf, ev_uf;
  logic              wd_act;
  logic [TIME_W-1:0] wd_time;
  logic              wd_expire, wd_new, wd_ext;
  logic [2:0]        ev_up, ev_dn;
  logic              queued;

  function automatic logic [CNT_W:0] step(input logic [CNT_W-1:0] cur,
                                          input logic [2:0] up,
                                          input logic [2:0] dn);
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] dif;
    sum = SUM_W'(cur) + SUM_W'(up);
    if (sum < SUM_W'(dn)) return {1'b1, {CNT_W{1'b0}}};
    dif = sum - SUM_W'(dn);
    if (dif > CNT_MAX) return {1'b0, {CNT_W{1'b1}}};
    return {1'b0, dif[CNT_W-1:0]};
  endfunction

  assign wd_expire = wd_act && (now >= wd_time);
  assign wd_new    = wr_issue && (!wd_act || wd_expire);
  assign wd_ext    = wr_issue && wd_act && !wd_expire && (wr_ready_time > wd_time);

  assign ev_up = 3'(rd_issue) + 3'(pre_start) + 3'(ref_start) + 3'(wd_new);
  assign ev_dn = 3'(rd_resp_done) + 3'(pre_done) + 3'(ref_done) + 3'(wd_expire);

  assign {rd_uf, rd_nxt} = step(rd_cnt, 3'(rd_enq), 3'(rd_resp_done));
  assign {wr_uf, wr_nxt} = step(wr_cnt, 3'(wr_enq_new), 3'(wr_issue));
  assign {ev_uf, ev_nxt} = step(ev_cnt, ev_up, ev_dn);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_cnt        <= '0;
      wr_cnt        <= '0;
      ev_cnt        <= '0;
      underflow_err <= 1'b0;
    end else begin
      rd_cnt        <= rd_nxt;
      wr_cnt        <= wr_nxt;
      ev_cnt        <= ev_nxt;
      underflow_err <= underflow_err | rd_uf | wr_uf | ev_uf;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_act  <= 1'b0;
      wd_time <= '0;
    end else if (wd_new) begin
      wd_act  <= 1'b1;
      wd_time <= wr_ready_time;
    end else if (wd_expire) begin
      wd_act  <= 1'b0;
    end else if (wd_ext) begin
      wd_time <= wr_ready_time;
    end
  end

  assign queued    = next_dir_wr ? (wr_cnt != '0) : (rd_cnt != '0);
  assign lp_ready  = !queued && (ref_running || (ev_cnt == '0));
  assign sref_exit = (rd_cnt != '0) || (next_dir_wr && (wr_cnt != '0));
endmodule

// File: rtl/rank_idle_tracker_chk.sv
module rank_idle_tracker_chk #(
  parameter int TIME_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_enq,
  input logic              rd_resp_done,
  input logic              wr_issue,
  input logic              rd_issue,
  input logic              pre_done,
  input logic              ref_done,
  input logic [TIME_W-1:0] wr_ready_time,
  input logic              ref_running,
  input logic              lp_ready,
  input logic              sref_exit,
  input logic              underflow_err,
  input logic              wd_act,
  input logic [TIME_W-1:0] wd_time,
  input logic              wd_expire
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!underflow_err && !wd_act));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    underflow_err |=> underflow_err);

  a_r2_read_wakes: assert property (@(posedge clk) disable iff (rst)
    (rd_enq && !rd_resp_done) |=> sref_exit);

  a_r5_timer_start: assert property (@(posedge clk) disable iff (rst)
    (wr_issue && !wd_act) |=> wd_act);

  a_r5_timer_extend: assert property (@(posedge clk) disable iff (rst)
    (wr_issue && wd_act && !wd_expire && (wr_ready_time > wd_time))
      |=> (wd_time == $past(wr_ready_time)));

  a_r5_timer_monotone: assert property (@(posedge clk) disable iff (rst)
    (wd_act && !wd_expire) |=> (wd_act && (wd_time >= $past(wd_time))));

  a_r4_read_blocks_idle: assert property (@(posedge clk) disable iff (rst)
    (rd_issue && !rd_resp_done && !pre_done && !ref_done && !wd_expire)
      |=> (ref_running || !lp_ready));
endmodule

bind rank_idle_tracker rank_idle_tracker_chk #(.TIME_W(TIME_W)) u_chk (.*);

// File: tb/tb_rank_idle_tracker.sv
`timescale 1ns/1ps
module tb_rank_idle_tracker;
  localparam int TW = 32;
  localparam int NV = 16;
  // {rd_enq, rd_resp, wr_enq, rd_iss, pre_st, pre_dn, ref_st, ref_dn, dir_wr, ref_run, exp_lp, exp_sx, exp_err}
  localparam logic [12:0] VEC [NV] = '{
    13'b1_0_0_0_0_0_0_0_0_0_0_1_0,
    13'b0_0_0_0_0_0_0_0_1_0_1_1_0,
    13'b0_0_1_0_0_0_0_0_1_0_0_1_0,
    13'b0_0_0_1_0_0_0_0_0_0_0_1_0,
    13'b0_1_0_0_0_0_0_0_0_0_1_0_0,
    13'b0_0_0_0_0_0_0_0_1_0_0_1_0,
    13'b0_0_0_0_1_0_0_0_0_0_0_0_0,
    13'b0_0_0_0_0_0_0_0_0_1_1_0_0,
    13'b0_0_0_0_0_1_0_0_0_0_1_0_0,
    13'b0_0_0_0_0_0_1_0_0_0_0_0_0,
    13'b1_0_0_1_0_0_0_1_0_0_0_1_0,
    13'b0_1_0_0_0_0_0_0_0_0_1_0_0,
    13'b1_1_0_1_0_0_0_0_0_0_1_0_0,
    13'b0_0_0_0_0_1_0_0_0_0_1_0_1,
    13'b0_0_0_0_1_0_0_0_0_0_0_0_1,
    13'b0_0_0_0_0_1_0_0_0_0_1_0_1
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_enq = 0, rd_resp_done = 0, wr_enq_new = 0, wr_issue = 0, rd_issue = 0;
  logic pre_start = 0, pre_done = 0, ref_start = 0, ref_done = 0;
  logic [TW-1:0] wr_ready_time = '0, now = '0;
  logic next_dir_wr = 0, ref_running = 0;
  logic lp_ready, sref_exit, underflow_err;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  rank_idle_tracker #(.CNT_W(8), .TIME_W(TW)) dut (
    .clk(clk), .rst(rst), .rd_enq(rd_enq), .rd_resp_done(rd_resp_done),
    .wr_enq_new(wr_enq_new), .wr_issue(wr_issue), .rd_issue(rd_issue),
    .pre_start(pre_start), .pre_done(pre_done), .ref_start(ref_start),
    .ref_done(ref_done), .wr_ready_time(wr_ready_time), .now(now),
    .next_dir_wr(next_dir_wr), .ref_running(ref_running),
    .lp_ready(lp_ready), .sref_exit(sref_exit), .underflow_err(underflow_err));

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {lp,sx,err} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic idle();
    {rd_enq, rd_resp_done, wr_enq_new, wr_issue, rd_issue} = '0;
    {pre_start, pre_done, ref_start, ref_done} = '0;
  endtask

  task automatic cycle();
    @(negedge clk);
  endtask

  task automatic do_reset();
    idle();
    rst = 1'b1;
    cycle();
    cycle();
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    check("R1 reset dir read", {lp_ready, sref_exit, underflow_err}, 3'b100);
    next_dir_wr = 1'b1;
    #1 check("R1 reset dir write", {lp_ready, sref_exit, underflow_err}, 3'b100);
    next_dir_wr = 1'b0;

    for (int i = 0; i < NV; i++) begin
      {rd_enq, rd_resp_done, wr_enq_new, rd_issue, pre_start, pre_done,
       ref_start, ref_done, next_dir_wr, ref_running} = VEC[i][12:3];
      cycle();
      check($sformatf("vec %0d (R2 R3 R4 R6 R7 R8 R9 R10)", i),
            {lp_ready, sref_exit, underflow_err}, VEC[i][2:0]);
    end

    // Write-completion timer
    ref_running = 1'b0;
    do_reset();
    now = 100;
    next_dir_wr = 1'b1;
    wr_enq_new = 1;
    cycle();
    check("R3 write queued", {lp_ready, sref_exit, underflow_err}, 3'b010);
    idle(); wr_issue = 1; wr_ready_time = 150;
    cycle();
    check("R3 R5 write issued, timer pending", {lp_ready, sref_exit, underflow_err}, 3'b000);
    idle(); wr_enq_new = 1; wr_issue = 1; wr_ready_time = 200;
    cycle();
    check("R5 extend to 200", {lp_ready, sref_exit, underflow_err}, 3'b000);
    idle(); wr_enq_new = 1; wr_issue = 1; wr_ready_time = 120;
    cycle();
    check("R5 earlier time ignored", {lp_ready, sref_exit, underflow_err}, 3'b000);
    idle(); now = 150;
    cycle();
    check("R5 old deadline passed, still pending", {lp_ready, sref_exit, underflow_err}, 3'b000);
    now = 199;
    cycle();
    check("R5 one before deadline", {lp_ready, sref_exit, underflow_err}, 3'b000);
    now = 200;
    cycle();
    check("R5 expiry removes single event", {lp_ready, sref_exit, underflow_err}, 3'b100);
    now = 300; wr_enq_new = 1; wr_issue = 1; wr_ready_time = 310;
    cycle();
    check("R5 restart after expiry", {lp_ready, sref_exit, underflow_err}, 3'b000);
    idle(); now = 310;
    cycle();
    check("R5 second expiry", {lp_ready, sref_exit, underflow_err}, 3'b100);

    // Saturation
    do_reset();
    next_dir_wr = 1'b0;
    rd_enq = 1;
    repeat (260) cycle();
    idle();
    check("R11 read count full", {lp_ready, sref_exit, underflow_err}, 3'b010);
    rd_issue = 1; rd_resp_done = 1;
    repeat (254) cycle();
    check("R11 one read left after 254 drains", {lp_ready, sref_exit, underflow_err}, 3'b010);
    cycle();
    idle();
    check("R11 drained at 255", {lp_ready, sref_exit, underflow_err}, 3'b100);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule